// File: doc/BRIEF.md
# Multi-Discipline Shared Bus Arbiter

This block decides which of N devices may drive a single shared bus. Every device raises its own request line and watches its own grant line, and a bus-busy input reports whether a transfer is still in progress. Arbitration happens only when no grant is outstanding and the bus is idle. The winner keeps its grant for as long as it holds its request, so a long transfer can run well past any scheduling boundary.

A three-bit mode input picks one of five service disciplines. The first is fixed priority by position, where the lowest index wins. The second is a time-division slot scheme: the slot owner rotates every programmable number of cycles, and a slot whose owner is not requesting is wasted. The third favours the device that has gone longest without the bus. The fourth is a ring of priorities measured from the device granted last. The fifth serves devices in the order their requests rose. The mode can be changed at run time. A new mode is picked up only at an edge where the bus is idle and nothing is granted, so a discipline never changes in the middle of a tenure.

Top module: `arb_multi_bus`

## Requirements
- R1: `gnt_o` has at most one bit set, is all zero during and just after reset, and a grant is only ever given to a device whose `req_i` bit was high at the deciding edge.
- R2: A new grant is decided at a clock edge where no grant is held and `bus_busy_i` is low, and it is visible after that edge. While `bus_busy_i` is high, no new grant is issued.
- R3: A grant stays unchanged while the holder keeps its request high. It clears after the first edge at which the holder's request is low. The next grant can be issued no earlier than the edge after that.
- R4: Mode code 0 (fixed priority): the requesting device with the lowest index wins.
- R5: Mode code 1 (time slots): a slot owner index starts at 0 after reset and advances by one (wrapping after N-1) every `slot_len_i` cycles, in every mode (a length of 0 counts as 1). Only the slot owner can be granted, and an idle slot produces no grant.
- R6: In mode 1, a holder keeps its grant across slot boundaries until it drops its request.
- R7: Mode code 2 (least recently used): the winner is the requester granted longest ago. The usage order starts as index 0 oldest up to index N-1 newest after reset, and every grant in any mode moves the granted device to newest.
- R8: Mode code 3 (rotating ring): the reference is the device granted most recently in any mode, or device N-1 after reset. Priority runs reference+1, reference+2, and so on around the ring, with the reference itself last.
- R9: Mode code 4 (arrival order): requesters are served in the order their request lines rose. Requests that rise in the same cycle are ordered by ascending index.
- R10: The mode input is captured only at an edge where no grant is held and `bus_busy_i` is low. The captured mode governs decisions from the next edge on. Codes 5 to 7 behave as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_DEV | Per-device bus request |
| bus_busy_i | input | 1 | High while a transfer occupies the bus |
| mode_i | input | 3 | Discipline select (0 to 4 valid) |
| slot_len_i | input | SLOT_W | Cycles per time slot in mode 1 |
| gnt_o | output | N_DEV | One-hot grant, zero when nobody holds the bus |

## Verification
A corrupted usage order, arrival order or ring reference does not show up at the ports straight away. It shows up at the next arbitration in the affected mode, when a different device is granted one cycle after the bus goes idle. The vectors therefore build up history in one mode and then arbitrate in another. This exposes any state that fails to update in every mode. A slot counter that is off by any amount moves the first grant in mode 1 to a different cycle. A mode captured at the wrong moment produces a grant that the intended discipline would not give, on the first idle edge after the holder releases.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;

  typedef enum logic [2:0] {
    ARB_STATIC  = 3'd0,
    ARB_SLOT    = 3'd1,
    ARB_LRU     = 3'd2,
    ARB_RING    = 3'd3,
    ARB_ARRIVAL = 3'd4
  } arb_mode_e;

  // Unused codes fall back to fixed priority.
  function automatic arb_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd1:    return ARB_SLOT;
      3'd2:    return ARB_LRU;
      3'd3:    return ARB_RING;
      3'd4:    return ARB_ARRIVAL;
      default: return ARB_STATIC;
    endcase
  endfunction

endpackage

// File: rtl/arb_oldest_pick.sv
`timescale 1ns/1ps
// Picks the candidate that no other candidate precedes.
// older[j][i] = 1 means device j ranks ahead of device i.
module arb_oldest_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0][N-1:0] older,
  input  logic [N-1:0]        cand,
  output logic                win_vld,
  output logic [IW-1:0]       win_idx
);

  logic [N-1:0] beaten;
  logic [N-1:0] eligible;

  always_comb begin
    beaten = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (j != i && cand[j] && older[j][i]) beaten[i] = 1'b1;
      end
    end
  end

  assign eligible = cand & ~beaten;

  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!win_vld && eligible[i]) begin
        win_vld = 1'b1;
        win_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/arb_slot_timer.sv
`timescale 1ns/1ps
// Rotating slot owner; advances every slot_len cycles (0 counts as 1).
module arb_slot_timer #(
  parameter int N = 4,
  parameter int SLOT_W = 8,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_len,
  output logic [IW-1:0]     slot_idx
);

  logic [SLOT_W-1:0] cnt_q;
  logic              slot_end;

  assign slot_end = (slot_len == '0) || (cnt_q == slot_len - SLOT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      slot_idx <= '0;
    end else if (slot_end) begin
      cnt_q    <= '0;
      slot_idx <= (slot_idx == IW'(N - 1)) ? '0 : slot_idx + IW'(1);
    end else begin
      cnt_q <= cnt_q + SLOT_W'(1);
    end
  end

endmodule

// File: rtl/arb_lru_order.sv
`timescale 1ns/1ps
// Usage order as a precedence matrix; a grant moves its device to newest.
module arb_lru_order #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          upd_vld,
  input  logic [IW-1:0] upd_idx,
  output logic          win_vld,
  output logic [IW-1:0] win_idx
);

  logic [N-1:0][N-1:0] older_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          older_q[i][j] <= (i < j);
        end
      end
    end else if (upd_vld) begin
      for (int j = 0; j < N; j++) begin
        if (IW'(j) != upd_idx) begin
          older_q[upd_idx][j] <= 1'b0;
          older_q[j][upd_idx] <= 1'b1;
        end
      end
    end
  end

  arb_oldest_pick #(.N(N)) u_pick (
    .older   (older_q),
    .cand    (req),
    .win_vld (win_vld),
    .win_idx (win_idx)
  );

endmodule

// File: rtl/arb_arrival_order.sv
`timescale 1ns/1ps
// Arrival order as a precedence matrix; rising requests become newest,
// simultaneous risers ranked by ascending index.
module arb_arrival_order #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          win_vld,
  output logic [IW-1:0] win_idx
);

  logic [N-1:0]        req_q;
  logic [N-1:0]        arrive;
  logic [N-1:0][N-1:0] older_q;
  logic [N-1:0][N-1:0] older_nxt;

  assign arrive = req & ~req_q;

  always_comb begin
    older_nxt = older_q;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i != j) begin
          if (arrive[i] && arrive[j]) older_nxt[i][j] = (i < j);
          else if (arrive[i])         older_nxt[i][j] = 1'b0;
          else if (arrive[j])         older_nxt[i][j] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          older_q[i][j] <= (i < j);
        end
      end
    end else begin
      req_q   <= req;
      older_q <= older_nxt;
    end
  end

  arb_oldest_pick #(.N(N)) u_pick (
    .older   (older_nxt),
    .cand    (req),
    .win_vld (win_vld),
    .win_idx (win_idx)
  );

endmodule

// File: rtl/arb_multi_bus.sv
`timescale 1ns/1ps
module arb_multi_bus
  import arb_pkg::*;
#(
  parameter int N_DEV  = 4,
  parameter int SLOT_W = 8,
  localparam int IW = $clog2(N_DEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DEV-1:0]  req_i,
  input  logic              bus_busy_i,
  input  logic [2:0]        mode_i,
  input  logic [SLOT_W-1:0] slot_len_i,
  output logic [N_DEV-1:0]  gnt_o
);

  // {valid, index}: lowest requesting index.
  function automatic logic [IW:0] pick_lowest(input logic [N_DEV-1:0] r);
    logic [IW:0] res;
    res = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (r[i]) res = {1'b1, IW'(i)};
    end
    return res;
  endfunction

  // {valid, index}: first requester after base, walking the ring; base last.
  function automatic logic [IW:0] pick_ring(input logic [N_DEV-1:0] r,
                                            input logic [IW-1:0]  base);
    logic [IW:0] res;
    res = '0;
    for (int s = N_DEV; s >= 1; s--) begin
      int t;
      t = int'(base) + s;
      if (t >= N_DEV) t = t - N_DEV;
      if (r[IW'(t)]) res = {1'b1, IW'(t)};
    end
    return res;
  endfunction

  // State
  logic      own_vld;
  logic [IW-1:0] own_idx;
  arb_mode_e cur_mode;
  logic [IW-1:0] ring_base;

  // Named internal events
  logic          arb_window;
  logic          holder_release;
  logic          issue;
  logic          pick_vld;
  logic [IW-1:0] pick_idx;
  logic [IW-1:0] slot_idx;
  logic          lru_vld;
  logic [IW-1:0] lru_idx;
  logic          arr_vld;
  logic [IW-1:0] arr_idx;
  logic [IW:0]   low_pick;
  logic [IW:0]   ring_pick;

  assign arb_window     = !own_vld && !bus_busy_i;
  assign holder_release = own_vld && !req_i[own_idx];
  assign low_pick       = pick_lowest(req_i);
  assign ring_pick      = pick_ring(req_i, ring_base);
  assign issue          = arb_window && pick_vld;

  arb_slot_timer #(.N(N_DEV), .SLOT_W(SLOT_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_len (slot_len_i),
    .slot_idx (slot_idx)
  );

  arb_lru_order #(.N(N_DEV)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_i),
    .upd_vld (issue),
    .upd_idx (pick_idx),
    .win_vld (lru_vld),
    .win_idx (lru_idx)
  );

  arb_arrival_order #(.N(N_DEV)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_i),
    .win_vld (arr_vld),
    .win_idx (arr_idx)
  );

  always_comb begin
    case (cur_mode)
      ARB_SLOT: begin
        pick_vld = req_i[slot_idx];
        pick_idx = slot_idx;
      end
      ARB_LRU: begin
        pick_vld = lru_vld;
        pick_idx = lru_idx;
      end
      ARB_RING: begin
        pick_vld = ring_pick[IW];
        pick_idx = ring_pick[IW-1:0];
      end
      ARB_ARRIVAL: begin
        pick_vld = arr_vld;
        pick_idx = arr_idx;
      end
      default: begin
        pick_vld = low_pick[IW];
        pick_idx = low_pick[IW-1:0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld   <= 1'b0;
      own_idx   <= '0;
      cur_mode  <= ARB_STATIC;
      ring_base <= IW'(N_DEV - 1);
    end else begin
      if (arb_window) cur_mode <= decode_mode(mode_i);
      if (issue) begin
        own_vld   <= 1'b1;
        own_idx   <= pick_idx;
        ring_base <= pick_idx;
      end else if (holder_release) begin
        own_vld <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < N_DEV; k++) begin : g_gnt
    assign gnt_o[k] = own_vld && (own_idx == IW'(k));
  end

endmodule

// File: rtl/arb_multi_bus_chk.sv
`timescale 1ns/1ps
module arb_multi_bus_chk #(
  parameter int N_DEV = 4,
  localparam int IW = $clog2(N_DEV)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DEV-1:0] req,
  input logic             busy,
  input logic [N_DEV-1:0] gnt,
  input logic [2:0]       mode_q,
  input logic [IW-1:0]    slot_idx
);

  // R1
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R1
  grant_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> ((gnt & ~$past(req)) == '0));

  // R2
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && busy) |=> (gnt == '0));

  // R3
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & req) != '0) |=> (gnt == $past(gnt)));

  // R3
  release_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && (gnt & req) == '0) |=> (gnt == '0));

  // R4
  static_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && !busy && mode_q == 3'd0)
      |=> (gnt == ($past(req) & (~$past(req) + N_DEV'(1)))));

  // R5
  slot_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && !busy && mode_q == 3'd1)
      |=> (gnt == ((N_DEV'(1) << $past(slot_idx)) & $past(req))));

endmodule

bind arb_multi_bus arb_multi_bus_chk #(.N_DEV(N_DEV)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req_i),
  .busy     (bus_busy_i),
  .gnt      (gnt_o),
  .mode_q   (cur_mode),
  .slot_idx (slot_idx)
);

// File: tb/sim_arb_multi_bus.sv
`timescale 1ns/1ps
module sim_arb_multi_bus;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic       busy = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] slot_len = 8'd3;
  logic [3:0] gnt;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  arb_multi_bus #(.N_DEV(4), .SLOT_W(8)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .bus_busy_i (busy),
    .mode_i     (mode),
    .slot_len_i (slot_len),
    .gnt_o      (gnt)
  );

  // {mode, busy, req, expected grant after the edge}
  localparam logic [11:0] VEC [0:47] = '{
    {3'd0,1'b0,4'b0000,4'b0000}, {3'd0,1'b1,4'b1110,4'b0000},
    {3'd0,1'b0,4'b1110,4'b0010}, {3'd0,1'b0,4'b1110,4'b0010},
    {3'd0,1'b0,4'b1100,4'b0000}, {3'd0,1'b0,4'b1100,4'b0100},
    {3'd0,1'b0,4'b0000,4'b0000}, {3'd2,1'b0,4'b0000,4'b0000},
    {3'd2,1'b0,4'b1111,4'b0001}, {3'd2,1'b0,4'b1110,4'b0000},
    {3'd2,1'b0,4'b1110,4'b1000}, {3'd2,1'b0,4'b0110,4'b0000},
    {3'd2,1'b0,4'b0111,4'b0010}, {3'd2,1'b0,4'b0000,4'b0000},
    {3'd3,1'b0,4'b0000,4'b0000}, {3'd3,1'b0,4'b1111,4'b0100},
    {3'd3,1'b0,4'b0000,4'b0000}, {3'd3,1'b0,4'b0111,4'b0001},
    {3'd3,1'b0,4'b0000,4'b0000}, {3'd3,1'b0,4'b0001,4'b0001},
    {3'd3,1'b0,4'b0000,4'b0000}, {3'd3,1'b0,4'b0011,4'b0010},
    {3'd3,1'b0,4'b0000,4'b0000}, {3'd4,1'b0,4'b0000,4'b0000},
    {3'd4,1'b1,4'b1000,4'b0000}, {3'd4,1'b1,4'b1010,4'b0000},
    {3'd4,1'b1,4'b1011,4'b0000}, {3'd4,1'b0,4'b1011,4'b1000},
    {3'd4,1'b0,4'b0011,4'b0000}, {3'd4,1'b0,4'b0111,4'b0010},
    {3'd4,1'b0,4'b0101,4'b0000}, {3'd4,1'b0,4'b0101,4'b0001},
    {3'd4,1'b0,4'b0100,4'b0000}, {3'd4,1'b0,4'b0100,4'b0100},
    {3'd0,1'b0,4'b0100,4'b0100}, {3'd0,1'b0,4'b0000,4'b0000},
    {3'd4,1'b0,4'b0000,4'b0000}, {3'd4,1'b1,4'b1000,4'b0000},
    {3'd0,1'b1,4'b1001,4'b0000}, {3'd4,1'b0,4'b1001,4'b1000},
    {3'd4,1'b0,4'b0000,4'b0000}, {3'd4,1'b0,4'b0010,4'b0010},
    {3'd0,1'b0,4'b1010,4'b0010}, {3'd4,1'b0,4'b1001,4'b0000},
    {3'd4,1'b0,4'b1001,4'b1000}, {3'd4,1'b0,4'b0001,4'b0000},
    {3'd4,1'b0,4'b0001,4'b0001}, {3'd4,1'b0,4'b0000,4'b0000}
  };

  function automatic string vec_req(input int k);
    if (k == 0) return "R1";
    if (k == 1 || (k >= 24 && k <= 26)) return "R2";
    if (k == 2 || k == 5) return "R4";
    if (k == 3 || k == 4 || k == 6) return "R3";
    if (k >= 8 && k <= 13) return "R7";
    if (k >= 15 && k <= 22) return "R8";
    if (k >= 27 && k <= 33) return "R9";
    return "R10";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: gnt=%b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0;
    busy = 1'b0;
    mode = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset state", gnt, 4'b0000);
    rst_n = 1'b1;
  endtask

  task automatic step(input string tag, input string what,
                      input logic [3:0] exp);
    @(posedge clk);
    @(negedge clk);
    check(tag, what, gnt, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: gnt=%b expected run to finish", gnt);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // Table walk: drive at negedge, compare after the following edge.
    for (int k = 0; k < 48; k++) begin
      mode = VEC[k][11:9];
      busy = VEC[k][8];
      req  = VEC[k][7:4];
      step(vec_req(k), $sformatf("vector %0d", k), VEC[k][3:0]);
    end

    // R5: slot owner before edge e is ((e-1)/3) mod 4; device 2 first at e7.
    slot_len = 8'd3;
    do_reset();
    mode = 3'd1;
    req  = 4'b0000;
    @(posedge clk);          // e1 captures slot mode
    @(negedge clk);
    req = 4'b0100;
    for (int e = 2; e <= 6; e++) begin
      step("R5", $sformatf("slot wasted at edge %0d", e), 4'b0000);
    end
    step("R5", "slot owner 2 granted", 4'b0100);
    // R6: holds across the slot boundary at e10
    for (int e = 8; e <= 11; e++) begin
      step("R6", $sformatf("hold past slot edge %0d", e), 4'b0100);
    end
    req = 4'b0000;
    step("R3", "release after slot hold", 4'b0000);
    // R10: code 5 acts as fixed priority
    mode = 3'd5;
    step("R10", "capture code 5", 4'b0000);
    req = 4'b1010;
    step("R10", "code 5 picks lowest index", 4'b0010);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule